// File: doc/BRIEF.md
# Hit/Miss Event Counter Pair

This block counts cache lookups for performance profiling. It has two counters, one for hit events and one for miss events. Each counter has its own run control and its own clear control. While a counter's run bit is set, every clock cycle in which its event pulse is high adds one to its count. When its run bit is cleared, the counter keeps its current value. While its clear bit is set, the counter is held at zero.

The counters saturate. A counter that reaches its all-ones value stays there until it is cleared, so a long profiling run cannot wrap around and show a small count. Software reads either count through a select input and a single data output.

Top module: `perfmon_top`

## Requirements
- R1: After reset both counters read zero.
- R2: The control field `ctrlBits` uses this encoding: bit 0 runs the hit counter, bit 1 runs the miss counter, bit 2 clears the hit counter, bit 3 clears the miss counter. Each clear bit sits two positions above the run bit of the same counter.
- R3: While the hit counter's run bit is 1 and its clear bit is 0, each clock edge with `hitEvent` high adds one to the hit count. The new count is readable after that edge.
- R4: While the miss counter's run bit is 1 and its clear bit is 0, each clock edge with `missEvent` high adds one to the miss count. The new count is readable after that edge.
- R5: Events of one kind never change the other counter, and a counter whose run bit is 0 ignores its own events.
- R6: Clearing a run bit freezes that counter's value. The value is not reset to zero.
- R7: While a clear bit is 1, that counter reads zero and ignores its events.
- R8: When a clear bit and an event for the same counter are both present in a cycle, the clear wins and the count ends at zero.
- R9: A counter at its all-ones value stays at all-ones when further events arrive. It does not wrap.
- R10: After its clear bit returns to 0, a running counter counts again from zero.
- R11: `rdData` shows the hit count when `rdSel` is 0 and the miss count when `rdSel` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| ctrlBits | input | 4 | Run and clear controls for both counters |
| hitEvent | input | 1 | Single-cycle hit pulse |
| missEvent | input | 1 | Single-cycle miss pulse |
| rdSel | input | 1 | Read select: 0 selects hit, 1 selects miss |
| rdData | output | CNT_WIDTH | Selected count (32 bits by default) |

## Verification
The bench builds the block with `CNT_WIDTH` set to 4. At that width the all-ones value of 15 is reached within twenty event cycles, so the bench can drive a counter into saturation and push past it directly. The counting, freezing, clearing and read-select paths do not depend on the width, so the narrow build exercises them in the same way as the 32-bit default.

// File: rtl/perfmon_pkg.sv
package perfmon_pkg;
  localparam int NUM_CNT    = 2;
  localparam int HIT_IDX    = 0;
  localparam int MISS_IDX   = 1;
  localparam int RST_OFFSET = 2;
  localparam int CTRL_W     = NUM_CNT + RST_OFFSET;

  typedef struct packed {
    logic [NUM_CNT-1:0] bump;
    logic [NUM_CNT-1:0] zero;
  } monStrobe_t;
endpackage

// File: rtl/perfmon_ctrl.sv
module perfmon_ctrl
  import perfmon_pkg::*;
(
  input  logic [CTRL_W-1:0]  ctrlBits,
  input  logic [NUM_CNT-1:0] eventVec,
  output monStrobe_t         strb
);
  always_comb begin
    strb = '0;
    for (int i = 0; i < NUM_CNT; i++) begin
      strb.zero[i] = ctrlBits[i + RST_OFFSET];
      strb.bump[i] = ctrlBits[i] & eventVec[i] & ~ctrlBits[i + RST_OFFSET];
    end
  end
endmodule

// File: rtl/perfmon_dp.sv
module perfmon_dp
  import perfmon_pkg::*;
#(
  parameter int CNT_WIDTH = 32
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  monStrobe_t           strb,
  input  logic                 rdSel,
  output logic [CNT_WIDTH-1:0] rdData
);
  localparam logic [CNT_WIDTH-1:0] CNT_MAX = '1;

  logic [CNT_WIDTH-1:0] cntQ [NUM_CNT];

  for (genvar g = 0; g < NUM_CNT; g++) begin : gCnt
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                              cntQ[g] <= '0;
      else if (strb.zero[g])                  cntQ[g] <= '0;
      else if (strb.bump[g] && cntQ[g] != CNT_MAX)
                                              cntQ[g] <= cntQ[g] + 1'b1;
    end

    assert_clear_zero_R7: assert property (@(posedge clk) disable iff (!rstN)
      strb.zero[g] |=> (cntQ[g] == '0));

    assert_no_overflow_R9: assert property (@(posedge clk) disable iff (!rstN)
      (cntQ[g] == CNT_MAX && !strb.zero[g]) |=> (cntQ[g] == CNT_MAX));

    assert_hold_R6: assert property (@(posedge clk) disable iff (!rstN)
      (!strb.bump[g] && !strb.zero[g]) |=> $stable(cntQ[g]));

    assert_step_R3: assert property (@(posedge clk) disable iff (!rstN)
      (strb.bump[g] && cntQ[g] != CNT_MAX) |=>
        (cntQ[g] == CNT_WIDTH'($past(cntQ[g]) + 1'b1)));
  end

  assign rdData = rdSel ? cntQ[MISS_IDX] : cntQ[HIT_IDX];
endmodule

// File: rtl/perfmon_top.sv
module perfmon_top
  import perfmon_pkg::*;
#(
  parameter int CNT_WIDTH = 32
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [3:0]           ctrlBits,
  input  logic                 hitEvent,
  input  logic                 missEvent,
  input  logic                 rdSel,
  output logic [CNT_WIDTH-1:0] rdData
);
  monStrobe_t         strb;
  logic [NUM_CNT-1:0] eventVec;

  always_comb begin
    eventVec           = '0;
    eventVec[HIT_IDX]  = hitEvent;
    eventVec[MISS_IDX] = missEvent;
  end

  perfmon_ctrl u_ctrl (
    .ctrlBits (ctrlBits),
    .eventVec (eventVec),
    .strb     (strb)
  );

  perfmon_dp #(.CNT_WIDTH(CNT_WIDTH)) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .strb   (strb),
    .rdSel  (rdSel),
    .rdData (rdData)
  );
endmodule

// File: tb/perfmon_top_tb.sv
module perfmon_top_tb;
  localparam int W = 4;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic [3:0]   ctrlBits = '0;
  logic         hitEvent = 1'b0;
  logic         missEvent = 1'b0;
  logic         rdSel = 1'b0;
  logic [W-1:0] rdData;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  perfmon_top #(.CNT_WIDTH(W)) u_dut (
    .clk(clk), .rstN(rstN), .ctrlBits(ctrlBits), .hitEvent(hitEvent),
    .missEvent(missEvent), .rdSel(rdSel), .rdData(rdData)
  );

  task automatic check(input string tag, input logic sel, input int exp);
    rdSel = sel;
    #1;
    checks++;
    if (int'(rdData) != exp) begin
      fails++;
      $display("FAIL %s sel=%0d got=%0d exp=%0d", tag, sel, rdData, exp);
    end
  endtask

  task automatic run(input int n, input logic h, input logic m);
    for (int k = 0; k < n; k++) begin
      @(negedge clk); hitEvent = h; missEvent = m;
    end
    @(negedge clk); hitEvent = 1'b0; missEvent = 1'b0;
  endtask

  task automatic setCtrl(input logic [3:0] v);
    @(negedge clk); ctrlBits = v;
  endtask

  task automatic tReset();
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 hit", 1'b0, 0);
    check("R1 miss", 1'b1, 0);
  endtask

  task automatic tHitOnly();
    setCtrl(4'b0001);                 // R2 bit0 runs hit
    run(3, 1'b1, 1'b1);
    check("R3 hit count", 1'b0, 3);
    check("R5 miss idle", 1'b1, 0);
  endtask

  task automatic tMissOnly();
    setCtrl(4'b0010);                 // R2 bit1 runs miss
    run(2, 1'b1, 1'b1);
    check("R4 miss count", 1'b1, 2);
    check("R6 hit frozen", 1'b0, 3);
  endtask

  task automatic tBoth();
    setCtrl(4'b0011);
    run(2, 1'b1, 1'b0);
    run(1, 1'b1, 1'b1);
    check("R11 hit sel0", 1'b0, 6);
    check("R11 miss sel1", 1'b1, 3);
  endtask

  task automatic tClearHit();
    setCtrl(4'b0111);                 // R2 bit2 clears hit
    run(2, 1'b1, 1'b1);
    check("R8 clear wins", 1'b0, 0);
    check("R5 miss unaffected", 1'b1, 5);
    setCtrl(4'b0011);
    run(1, 1'b1, 1'b0);
    check("R10 resume", 1'b0, 1);
  endtask

  task automatic tSaturate();
    setCtrl(4'b0001);
    run(20, 1'b1, 1'b1);
    check("R9 saturate", 1'b0, 15);
    run(2, 1'b1, 1'b0);
    check("R9 no wrap", 1'b0, 15);
    check("R6 miss frozen", 1'b1, 5);
  endtask

  task automatic tClearMiss();
    setCtrl(4'b1010);                 // R2 bit3 clears miss
    run(3, 1'b0, 1'b1);
    check("R7 miss held zero", 1'b1, 0);
    check("R7 hit kept", 1'b0, 15);
    setCtrl(4'b0010);
    run(2, 1'b0, 1'b1);
    check("R10 miss resume", 1'b1, 2);
  endtask

  initial begin
    tReset();
    tHitOnly();
    tMissOnly();
    tBoth();
    tClearHit();
    tSaturate();
    tClearMiss();
    if (!done) begin
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule